// File: doc/BRIEF.md
# Dual-Channel Line Formatter with Per-Line CRC

This block combines the samples of two converter channels into one word stream for a single serializer lane. One input cycle brings a pair of samples. The block sends them out over the next two word slots, channel A first and then channel B, so the lane runs at twice the pair rate.

While a line is open, every pixel word also goes through a 10-bit CRC. The CRC is preset at each line opening. After the last pixel of the line it is placed on the data lane for one slot. The block also drives a second lane, the sync lane, which stays slot-aligned with the data lane. It marks where frames and lines open and close, and it carries an idle code in every other slot.

A mode input selects full 10-bit words or 8-bit words. In 8-bit mode the block narrows the pixel words, the code words and the CRC together.

Top module: `line_formatter`

## Requirements
- R1: While reset is held and on the first slot after it (in 10-bit mode), the data lane shows the training word 0x3A6 and the sync lane shows the idle code 0x015.
- R2: A line-open strobe produces a slot, one cycle later, where the sync lane shows 0x0AA. If the first-line flag is set with that strobe, the sync lane shows 0x2AA instead. The data lane shows the training word in that slot.
- R3: A sample pair accepted inside an open line appears on the data lane in the next two slots, A first and then B. The sync lane shows idle in both slots.
- R4: The CRC register is set to all ones by a line-open strobe. It then absorbs each pixel word MSB first, using feedback mask 0x233 (x^10+x^9+x^5+x^4+x+1).
- R5: A line-close strobe produces a slot, one cycle later, where the data lane shows the CRC of all pixel words of the line. In that slot the sync lane shows 0x12A, or 0x3AA if the last-line flag accompanies the strobe. The line is then closed.
- R6: When the narrow-mode input is 1, each output word uses only bits [7:0], and bits [9:8] are zero. Pixel words are sample bits [9:2]. Codes and the training word are their own bits [9:2]. The CRC absorbs 8-bit words and shows its low 8 bits.
- R7: In any slot that has no pixel, CRC or marker, the data lane shows the training word and the sync lane shows idle. A sample strobe while no line is open is ignored.
- R8: A line with no pixels closes with CRC 0x3FF, or 0xFF in narrow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_narrow_i | input | 1 | 1 selects 8-bit words, 0 selects 10-bit words |
| line_open_i | input | 1 | Line-open strobe |
| first_line_i | input | 1 | Qualifies line_open_i as the first line of a frame |
| line_close_i | input | 1 | Line-close strobe |
| last_line_i | input | 1 | Qualifies line_close_i as the last line of a frame |
| pair_valid_i | input | 1 | A sample pair is present |
| chan_a_i | input | 10 | Channel A sample |
| chan_b_i | input | 10 | Channel B sample |
| lane_data_o | output | 10 | Data lane word |
| lane_sync_o | output | 10 | Sync lane word |

## Verification
The assertions rely on the inputs following a simple framing order. A line-open strobe arrives only while no line is open. Sample strobes never fall in the slot right after an accepted pair. A line-close strobe never coincides with a sample strobe or with the B slot. The mode changes only between frames.

The stimulus builds frames from these rules: random line counts, random pixel counts including empty lines, random gaps, and random sample strobes outside lines. The bench model therefore predicts every slot.

// File: rtl/df_pkg.sv
package df_pkg;

    localparam int SMP_W    = 10;
    localparam int NARROW_W = 8;
    localparam int DROP_W   = SMP_W - NARROW_W;

    typedef logic [SMP_W-1:0] word_t;

    localparam word_t CRC_MASK   = 10'h233;
    localparam word_t CRC_SEED   = '1;
    localparam word_t CODE_FRAME = 10'h2AA;
    localparam word_t CODE_LINE  = 10'h0AA;
    localparam word_t CODE_CLOSE = 10'h12A;
    localparam word_t CODE_LAST  = 10'h3AA;
    localparam word_t CODE_IDLE  = 10'h015;
    localparam word_t WORD_TRAIN = 10'h3A6;

    typedef enum logic [2:0] {
        SLOT_TRAIN,
        SLOT_PIX,
        SLOT_OPEN,
        SLOT_FIRST,
        SLOT_CLOSE,
        SLOT_LAST
    } slot_e;

    function automatic word_t fit_word(word_t w, logic narrow);
        word_t r;
        r = narrow ? {{DROP_W{1'b0}}, w[SMP_W-1:DROP_W]} : w;
        return r;
    endfunction

    function automatic word_t crc_step(word_t c, word_t d, logic narrow);
        word_t r;
        logic  fb;
        int    n;
        r = c;
        n = narrow ? NARROW_W : SMP_W;
        for (int i = SMP_W - 1; i >= 0; i--) begin
            if (i < n) begin
                fb = r[SMP_W-1] ^ d[i];
                r  = {r[SMP_W-2:0], 1'b0};
                if (fb) r = r ^ CRC_MASK;
            end
        end
        return r;
    endfunction

    function automatic word_t crc_view(word_t c, logic narrow);
        word_t r;
        r = narrow ? {{DROP_W{1'b0}}, c[NARROW_W-1:0]} : c;
        return r;
    endfunction

endpackage

// File: rtl/df_word_seq.sv
module df_word_seq
    import df_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  line_act_i,
    input  logic  valid_i,
    input  word_t a_i,
    input  word_t b_i,
    input  logic  narrow_i,
    output logic  fire_o,
    output word_t word_o
);
    logic  pend_q;
    word_t hold_q;
    logic  accept;

    assign accept = valid_i && line_act_i && !pend_q;
    assign fire_o = accept || pend_q;
    assign word_o = pend_q ? fit_word(hold_q, narrow_i) : fit_word(a_i, narrow_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= 1'b0;
            hold_q <= '0;
        end else if (pend_q) begin
            pend_q <= 1'b0;
        end else if (accept) begin
            pend_q <= 1'b1;
            hold_q <= b_i;
        end
    end

    AST_B_FOLLOWS_A: assert property (@(posedge clk_i) disable iff (rst_i)
        accept |=> (fire_o && word_o == fit_word($past(b_i), narrow_i))); // R3

endmodule

// File: rtl/df_crc.sv
module df_crc
    import df_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  preset_i,
    input  logic  fire_i,
    input  word_t word_i,
    input  logic  narrow_i,
    output word_t crc_o
);
    word_t crc_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || preset_i) begin
            crc_q <= CRC_SEED;
        end else if (fire_i) begin
            crc_q <= crc_step(crc_q, word_i, narrow_i);
        end
    end

    assign crc_o = crc_view(crc_q, narrow_i);

    AST_CRC_PRESET: assert property (@(posedge clk_i) disable iff (rst_i)
        preset_i |=> (crc_o == crc_view(CRC_SEED, narrow_i))); // R4

endmodule

// File: rtl/df_line_ctrl.sv
module df_line_ctrl
    import df_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  open_i,
    input  logic  first_i,
    input  logic  close_i,
    input  logic  last_i,
    input  logic  fire_i,
    output logic  line_act_o,
    output slot_e slot_o
);
    logic act_q;
    logic closing;

    assign closing    = close_i && act_q && !fire_i && !open_i;
    assign line_act_o = act_q;

    always_comb begin
        if (open_i)       slot_o = first_i ? SLOT_FIRST : SLOT_OPEN;
        else if (fire_i)  slot_o = SLOT_PIX;
        else if (closing) slot_o = last_i ? SLOT_LAST : SLOT_CLOSE;
        else              slot_o = SLOT_TRAIN;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        act_q <= 1'b0;
        else if (open_i)  act_q <= 1'b1;
        else if (closing) act_q <= 1'b0;
    end

    AST_OPEN_ACTIVATES: assert property (@(posedge clk_i) disable iff (rst_i)
        open_i |=> line_act_o); // R2
    AST_CLOSE_ENDS: assert property (@(posedge clk_i) disable iff (rst_i)
        closing |=> !line_act_o); // R5

endmodule

// File: rtl/line_formatter.sv
module line_formatter
    import df_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       mode_narrow_i,
    input  logic       line_open_i,
    input  logic       first_line_i,
    input  logic       line_close_i,
    input  logic       last_line_i,
    input  logic       pair_valid_i,
    input  logic [9:0] chan_a_i,
    input  logic [9:0] chan_b_i,
    output logic [9:0] lane_data_o,
    output logic [9:0] lane_sync_o
);
    logic  line_act;
    logic  fire;
    word_t pix_word;
    word_t crc_w;
    slot_e slot;
    word_t data_q, sync_q;

    df_word_seq u_seq (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .line_act_i (line_act),
        .valid_i    (pair_valid_i),
        .a_i        (chan_a_i),
        .b_i        (chan_b_i),
        .narrow_i   (mode_narrow_i),
        .fire_o     (fire),
        .word_o     (pix_word)
    );

    df_crc u_crc (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .preset_i (line_open_i),
        .fire_i   (fire && !line_open_i),
        .word_i   (pix_word),
        .narrow_i (mode_narrow_i),
        .crc_o    (crc_w)
    );

    df_line_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .open_i     (line_open_i),
        .first_i    (first_line_i),
        .close_i    (line_close_i),
        .last_i     (last_line_i),
        .fire_i     (fire),
        .line_act_o (line_act),
        .slot_o     (slot)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            data_q <= fit_word(WORD_TRAIN, mode_narrow_i);
            sync_q <= fit_word(CODE_IDLE, mode_narrow_i);
        end else begin
            unique case (slot)
                SLOT_PIX: begin
                    data_q <= pix_word;
                    sync_q <= fit_word(CODE_IDLE, mode_narrow_i);
                end
                SLOT_OPEN: begin
                    data_q <= fit_word(WORD_TRAIN, mode_narrow_i);
                    sync_q <= fit_word(CODE_LINE, mode_narrow_i);
                end
                SLOT_FIRST: begin
                    data_q <= fit_word(WORD_TRAIN, mode_narrow_i);
                    sync_q <= fit_word(CODE_FRAME, mode_narrow_i);
                end
                SLOT_CLOSE: begin
                    data_q <= crc_w;
                    sync_q <= fit_word(CODE_CLOSE, mode_narrow_i);
                end
                SLOT_LAST: begin
                    data_q <= crc_w;
                    sync_q <= fit_word(CODE_LAST, mode_narrow_i);
                end
                default: begin
                    data_q <= fit_word(WORD_TRAIN, mode_narrow_i);
                    sync_q <= fit_word(CODE_IDLE, mode_narrow_i);
                end
            endcase
        end
    end

    assign lane_data_o = data_q;
    assign lane_sync_o = sync_q;

    AST_CRC_ON_END: assert property (@(posedge clk_i) disable iff (rst_i)
        (slot == SLOT_CLOSE || slot == SLOT_LAST) |=> (lane_data_o == $past(crc_w))); // R5
    AST_TRAIN_WHEN_CLOSED: assert property (@(posedge clk_i) disable iff (rst_i)
        (!line_act && !line_open_i) |=> (lane_data_o == fit_word(WORD_TRAIN, $past(mode_narrow_i)))); // R7
    AST_NARROW_TOP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_narrow_i |=> (lane_data_o[9:8] == 2'b00 && lane_sync_o[9:8] == 2'b00)); // R6

endmodule

// File: tb/line_formatter_tb_top.sv
`timescale 1ns/1ps
module line_formatter_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       narrow, lopen, first, lclose, last, vld;
    logic [9:0] a, b;
    logic [9:0] data_o, sync_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    line_formatter dut_i (
        .clk_i         (clk),
        .rst_i         (rst),
        .mode_narrow_i (narrow),
        .line_open_i   (lopen),
        .first_line_i  (first),
        .line_close_i  (lclose),
        .last_line_i   (last),
        .pair_valid_i  (vld),
        .chan_a_i      (a),
        .chan_b_i      (b),
        .lane_data_o   (data_o),
        .lane_sync_o   (sync_o)
    );

    bit         m_act, m_pend;
    logic [9:0] m_hold, m_crc;

    function automatic logic [9:0] shrink(logic [9:0] v, bit nar);
        return nar ? (v >> 2) : v;
    endfunction

    function automatic logic [9:0] crc_upd(logic [9:0] c, logic [9:0] d, bit nar);
        logic [9:0] r = c;
        int         nb = nar ? 8 : 10;
        logic [9:0] sh = d << (10 - nb);
        for (int k = 0; k < nb; k++) begin
            bit top = r[9] ^ sh[9];
            sh = sh << 1;
            r  = r << 1;
            if (top) r = r ^ 10'b1000110011;
        end
        return r;
    endfunction

    task automatic check(string req, logic [9:0] got, logic [9:0] exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got 0x%03h expected 0x%03h", req, what, got, exp);
        end
    endtask

    task automatic step(bit so, bit sf, bit eo, bit ef, bit v, logic [9:0] xa, logic [9:0] xb,
                        string force_tag = "");
        logic [9:0] ed, es;
        string      tag;
        @(negedge clk);
        lopen = so; first = sf; lclose = eo; last = ef; vld = v; a = xa; b = xb;
        es = shrink(10'h015, narrow);
        ed = shrink(10'h3A6, narrow);
        tag = "R7";
        if (so) begin
            es = shrink(sf ? 10'h2AA : 10'h0AA, narrow);
            m_crc = 10'h3FF; m_act = 1; tag = "R2";
        end else if (m_pend) begin
            ed = shrink(m_hold, narrow); m_crc = crc_upd(m_crc, ed, narrow);
            m_pend = 0; tag = "R3";
        end else if (v && m_act) begin
            ed = shrink(xa, narrow); m_crc = crc_upd(m_crc, ed, narrow);
            m_hold = xb; m_pend = 1; tag = "R3";
        end else if (eo && m_act) begin
            ed = narrow ? (m_crc & 10'h0FF) : m_crc;
            es = shrink(ef ? 10'h3AA : 10'h12A, narrow);
            m_act = 0; tag = "R4 R5";
        end
        if (narrow) tag = {tag, " R6"};
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        #1;
        check(tag, data_o, ed, "data");
        check(tag, sync_o, es, "sync");
    endtask

    task automatic idle_steps(int n, bit noisy);
        for (int i = 0; i < n; i++)
            step(0, 0, 0, 0, noisy ? 1'($urandom_range(0, 1)) : 1'b0, 10'($urandom), 10'($urandom));
    endtask

    task automatic run_line(bit is_first, bit is_last, int npairs);
        step(1, is_first, 0, 0, 0, 0, 0);
        for (int p = 0; p < npairs; p++) begin
            idle_steps($urandom_range(0, 2), 0);
            step(0, 0, 0, 0, 1, 10'($urandom), 10'($urandom));
            step(0, 0, 0, 0, 0, 0, 0);
        end
        idle_steps($urandom_range(0, 1), 0);
        step(0, 0, 1, is_last, 0, 0, 0);
    endtask

    task automatic run_frame(bit nar, int nlines);
        @(negedge clk);
        narrow = nar;
        for (int l = 0; l < nlines; l++) begin
            run_line(l == 0, l == nlines - 1, $urandom_range(0, 5));
            idle_steps($urandom_range(0, 3), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; narrow = 0; lopen = 0; first = 0; lclose = 0; last = 0; vld = 0; a = 0; b = 0;
        m_act = 0; m_pend = 0; m_hold = 0; m_crc = 10'h3FF;
        repeat (3) @(posedge clk);
        #1;
        check("R1", data_o, 10'h3A6, "reset data");
        check("R1", sync_o, 10'h015, "reset sync");
        @(negedge clk);
        rst = 0;
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // R7: strobe outside a line is ignored
        step(0, 0, 0, 0, 1, 10'h155, 10'h2AA, "R7");
        step(0, 0, 0, 0, 0, 0, 0, "R7");
        // R8: empty lines in both modes
        step(1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0, 0, "R8");
        @(negedge clk); narrow = 1;
        step(1, 1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 1, 0, 0, 0, "R8 R6");
        @(negedge clk); narrow = 0;
        // R3 R4: directed pair with all-ones / zero samples
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1, 10'h3FF, 10'h000);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0, "R4");
        for (int f = 0; f < 40; f++)
            run_frame(1'($urandom_range(0, 1)), $urandom_range(1, 4));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule